// File: doc/BRIEF.md
# Pipelined Longest Prefix Match Engine

This block resolves IPv4 destination addresses to next-hop values by longest-prefix match against a routing table held in one shared memory. The table is a three-level trie: a first level indexed by the top 16 address bits, then two levels of 256-entry subtables, each indexed by one further byte. A lookup needs one, two or three dependent reads, depending on where it reaches a leaf.

Rather than giving each trie level its own pipeline stage, the engine runs a circular pipeline. Each new address takes a token from an in-order completion buffer and issues its first read. Every memory response is paired with the head of an in-flight queue. A leaf completes the lookup into the token's slot. A pointer sends the lookup straight back to memory with the next index. Lookups therefore finish out of order, and the completion buffer puts the results back in arrival order.

The table is loaded through a separate write port before lookups start. Addresses enter through a valid/ready input at up to one per cycle. Results leave through a valid/ready output.

Top module: `lpm_engine`

## Requirements
- R1: The first read uses `in_addr[31:16]` as the table index, reduced to its low `TBL_AW` bits.
- R2: If the first entry has bit 31 clear, the second read is at `(entry[15:0] + in_addr[15:8])` modulo the table size.
- R3: If the second entry also has bit 31 clear, the third read is at `(entry[15:0] + in_addr[7:0])` modulo the table size. The third entry's low `HOP_W` bits are delivered whatever its bit 31 holds.
- R4: An entry with bit 31 set is a leaf. The result is that entry's bits `[HOP_W-1:0]`.
- R5: Results appear on `out_hop` in the order the addresses were accepted, one per accepted address. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_hop` hold.
- R6: At most `NTOK` lookups are held between acceptance and delivery. When all tokens are taken, `in_ready` is low.
- R7: In a cycle where a memory response sends a lookup back to memory, `in_ready` is low, so the returning lookup wins the memory.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: The memory answers 4 cycles after a request. On an idle engine, the result of a lookup accepted in cycle A is first offered in cycle A+1+4·L, where L is the number of reads it needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address accepted this cycle when in_valid is also high |
| in_addr | input | 32 | IPv4 address to look up |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken this cycle when out_valid is also high |
| out_hop | output | HOP_W | Next-hop value |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | TBL_AW | Table write index |
| tbl_wdata | input | 32 | Table write entry |

## Verification
The assertions assume the table is not rewritten while lookups are in flight. The bench respects this by loading the whole table before the first address and never writing it again. They also assume that no response arrives without a queued lookup to pair it with. That holds only if every request entered the queue in its issue cycle, which the bench does not disturb, since it drives only the block's own ports. The stimulus varies `out_ready` freely, including long stalls that use up all tokens, so the token-limit and output-hold properties see their boundary cases.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ENTRY_W  = 32;
  localparam int LEAF_BIT = 31;
  localparam int REM_W    = 16;
  localparam int LVL_W    = 2;
  localparam logic [LVL_W-1:0] LVL_FIRST = 2'd1;
  localparam logic [LVL_W-1:0] LVL_LAST  = 2'd3;

  // leaf marker of a table entry
  function automatic logic is_leaf(input logic [ENTRY_W-1:0] entry);
    return entry[LEAF_BIT];
  endfunction

  // level-one index: upper half of the address
  function automatic logic [15:0] first_index(input logic [31:0] addr);
    return addr[31:16];
  endfunction

  // subtable index: pointer plus the leading byte of the remaining bits
  function automatic logic [15:0] child_index(input logic [ENTRY_W-1:0] entry,
                                              input logic [REM_W-1:0] rem);
    return entry[15:0] + {8'h00, rem[REM_W-1:REM_W-8]};
  endfunction

  // move the next byte into the leading position
  function automatic logic [REM_W-1:0] next_rem(input logic [REM_W-1:0] rem);
    return {rem[REM_W-9:0], 8'h00};
  endfunction
endpackage

// File: rtl/lpm_table_ram.sv
module lpm_table_ram #(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_idx,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] dpipe [LAT];
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    dpipe[0] <= cells[req_idx];
  end

  generate
    for (genvar s = 1; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
        dpipe[s] <= dpipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) vpipe <= '0;
    else if (LAT == 1) vpipe <= req_valid;
    else vpipe <= {vpipe[LAT-2:0], req_valid};
  end

  assign resp_valid = vpipe[LAT-1];
  assign resp_data  = dpipe[LAT-1];
endmodule

// File: rtl/lpm_flight_fifo.sv
module lpm_flight_fifo #(
  parameter int DW    = 21,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    slots [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = slots[rp];
endmodule

// File: rtl/lpm_cbuf.sv
module lpm_cbuf #(
  parameter int NTOK  = 8,
  parameter int HOP_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc,
  output logic [$clog2(NTOK)-1:0]   alloc_tok,
  output logic                      tok_avail,
  input  logic                      done,
  input  logic [$clog2(NTOK)-1:0]   done_tok,
  input  logic [HOP_W-1:0]          done_hop,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [HOP_W-1:0]          out_hop,
  output logic [$clog2(NTOK+1)-1:0] occ
);
  localparam int TOK_W = $clog2(NTOK);
  localparam int CNT_W = $clog2(NTOK + 1);

  logic [TOK_W-1:0] wr_ptr, rd_ptr;
  logic [NTOK-1:0]  slot_ok;
  logic [HOP_W-1:0] slot_hop [NTOK];
  logic             pop;

  assign tok_avail = (occ < CNT_W'(NTOK));
  assign alloc_tok = wr_ptr;
  assign out_valid = (occ != '0) && slot_ok[rd_ptr];
  assign out_hop   = slot_hop[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (done) slot_hop[done_tok] <= done_hop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      slot_ok <= '0;
    end else begin
      if (pop) begin
        slot_ok[rd_ptr] <= 1'b0;
        rd_ptr          <= rd_ptr + TOK_W'(1);
      end
      if (alloc) begin
        slot_ok[wr_ptr] <= 1'b0;
        wr_ptr          <= wr_ptr + TOK_W'(1);
      end
      if (done) slot_ok[done_tok] <= 1'b1;
      occ <= occ + CNT_W'(alloc) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
  import lpm_pkg::*;
#(
  parameter int TBL_AW  = 12,
  parameter int NTOK    = 8,
  parameter int HOP_W   = 16,
  parameter int MEM_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [HOP_W-1:0]   out_hop,
  input  logic               tbl_we,
  input  logic [TBL_AW-1:0]  tbl_widx,
  input  logic [ENTRY_W-1:0] tbl_wdata
);
  localparam int TOK_W = $clog2(NTOK);
  localparam int CNT_W = $clog2(NTOK + 1);
  localparam int FL_W  = LVL_W + REM_W + TOK_W;

  // named events, also observed by the checker
  logic               enter_fire;
  logic               recirc_fire;
  logic               done_fire;
  logic               resp_valid;
  logic [CNT_W-1:0]   tok_cnt;
  logic [CNT_W-1:0]   fifo_cnt;

  logic [ENTRY_W-1:0] resp_data;
  logic               mem_req;
  logic [TBL_AW-1:0]  mem_idx;
  logic               tok_avail;
  logic [TOK_W-1:0]   new_tok;
  logic [FL_W-1:0]    fl_head, fl_push;
  logic [LVL_W-1:0]   h_lvl;
  logic [REM_W-1:0]   h_rem;
  logic [TOK_W-1:0]   h_tok;
  logic               resp_final;

  assign {h_lvl, h_rem, h_tok} = fl_head;

  // a response finishes on a leaf or on the last trie level
  assign resp_final  = is_leaf(resp_data) || (h_lvl == LVL_LAST);
  assign done_fire   = resp_valid && resp_final;
  assign recirc_fire = resp_valid && !resp_final;

  // returning lookups have priority on the memory port
  assign in_ready   = tok_avail && !recirc_fire;
  assign enter_fire = in_valid && in_ready;
  assign mem_req    = enter_fire || recirc_fire;

  always_comb begin
    if (recirc_fire) begin
      mem_idx = TBL_AW'(child_index(resp_data, h_rem));
      fl_push = {h_lvl + LVL_W'(1), next_rem(h_rem), h_tok};
    end else begin
      mem_idx = TBL_AW'(first_index(in_addr));
      fl_push = {LVL_FIRST, in_addr[REM_W-1:0], new_tok};
    end
  end

  lpm_table_ram #(
    .AW (TBL_AW),
    .DW (ENTRY_W),
    .LAT(MEM_LAT)
  ) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (mem_req),
    .req_idx   (mem_idx),
    .resp_valid(resp_valid),
    .resp_data (resp_data),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_widx),
    .wr_data   (tbl_wdata)
  );

  lpm_flight_fifo #(
    .DW   (FL_W),
    .DEPTH(NTOK)
  ) u_flight (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (mem_req),
    .push_data(fl_push),
    .pop      (resp_valid),
    .head     (fl_head),
    .count    (fifo_cnt)
  );

  lpm_cbuf #(
    .NTOK (NTOK),
    .HOP_W(HOP_W)
  ) u_cbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (enter_fire),
    .alloc_tok(new_tok),
    .tok_avail(tok_avail),
    .done     (done_fire),
    .done_tok (h_tok),
    .done_hop (resp_data[HOP_W-1:0]),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_hop  (out_hop),
    .occ      (tok_cnt)
  );
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
  parameter int NTOK  = 8,
  parameter int HOP_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [HOP_W-1:0]          out_hop,
  input logic                      enter_fire,
  input logic                      recirc_fire,
  input logic                      resp_valid,
  input logic [$clog2(NTOK+1)-1:0] tok_cnt,
  input logic [$clog2(NTOK+1)-1:0] fifo_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= tok_cnt) else $error("in-flight entries exceed tokens"); // R6

  AST_TOKEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_cnt == ($clog2(NTOK+1))'(NTOK)) |-> !in_ready) else $error("accept with no token"); // R6

  AST_RECIRC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    recirc_fire |-> !(in_ready && in_valid && enter_fire)) else $error("new address beat recirculation"); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hop))) else $error("result dropped under stall"); // R5

  AST_OUT_HAS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tok_cnt != '0)) else $error("result without token"); // R5

  AST_RESP_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (fifo_cnt != '0)) else $error("response without queued lookup"); // R9
endmodule

bind lpm_engine lpm_engine_chk #(.NTOK(NTOK), .HOP_W(HOP_W)) u_chk (.*);

// File: tb/tb_lpm_engine.sv
`timescale 1ns/1ps
module tb_lpm_engine;
  localparam int AW    = 12;
  localparam int NTOK  = 8;
  localparam int HOP_W = 16;
  localparam int TSIZE = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [31:0]       in_addr;
  logic              out_valid;
  logic              out_ready;
  logic [HOP_W-1:0]  out_hop;
  logic              tbl_we;
  logic [AW-1:0]     tbl_widx;
  logic [31:0]       tbl_wdata;

  lpm_engine #(.TBL_AW(AW), .NTOK(NTOK), .HOP_W(HOP_W), .MEM_LAT(4)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, n_sent = 0, n_out = 0;
  int ready_mode = 0;
  int last_pop_cyc = 0;
  logic [HOP_W-1:0] last_pop_hop;
  logic [31:0] table_m [TSIZE];
  logic [HOP_W-1:0] exp_hop[$];
  int exp_lv[$];
  logic [31:0] seed = 32'h1234_5678;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // reference walk written from the requirements
  function automatic logic [HOP_W-1:0] walk(input logic [31:0] a, output int lv,
                                            output bit third_ptr);
    logic [31:0] e;
    int idx;
    third_ptr = 0;
    idx = int'(a >> 16) % TSIZE;
    e = table_m[idx]; lv = 1;
    if (e[31]) return e[HOP_W-1:0];
    idx = (int'(e & 32'hFFFF) + int'((a >> 8) & 32'hFF)) % TSIZE;
    e = table_m[idx]; lv = 2;
    if (e[31]) return e[HOP_W-1:0];
    idx = (int'(e & 32'hFFFF) + int'(a & 32'hFF)) % TSIZE;
    e = table_m[idx]; lv = 3;
    third_ptr = !e[31];
    return e[HOP_W-1:0];
  endfunction

  function automatic logic [31:0] find_addr(input int want, input bit want_ptr3);
    for (int k = 0; k < 100000; k++) begin
      logic [31:0] a;
      int lv;
      bit p3;
      a = rnd();
      void'(walk(a, lv, p3));
      if (lv == want && (!want_ptr3 || p3)) return a;
    end
    return 32'h0;
  endfunction

  int acc_cyc;
  task automatic send(input logic [31:0] a);
    int lv; bit p3; logic [HOP_W-1:0] h;
    in_valid = 1'b1;
    in_addr  = a;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    h = walk(a, lv, p3);
    exp_hop.push_back(h);
    exp_lv.push_back(lv);
    n_sent++;
    acc_cyc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_hop.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor and scoreboard
  bit stall_seen = 0;
  logic [HOP_W-1:0] stall_hop;
  always @(negedge clk) begin
    case (ready_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (cyc % 3) != 0;
    endcase
    #1;
    if (rst_n === 1'b1) begin
      if (stall_seen)
        check(out_valid && out_hop == stall_hop, "R5", "held result", out_hop, stall_hop);
      stall_seen = out_valid && !out_ready;
      stall_hop  = out_hop;
      if (out_valid && out_ready) begin
        if (exp_hop.size() == 0) begin
          check(0, "R5", "unexpected result", out_hop, 0);
        end else begin
          logic [HOP_W-1:0] eh;
          int el;
          eh = exp_hop.pop_front();
          el = exp_lv.pop_front();
          if (el == 1)      check(out_hop == eh, "R1", "one-read result", out_hop, eh);
          else if (el == 2) check(out_hop == eh, "R2", "two-read result", out_hop, eh);
          else              check(out_hop == eh, "R3", "three-read result", out_hop, eh);
        end
        n_out++;
        last_pop_cyc = cyc;
        last_pop_hop = out_hop;
      end
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; out_ready = 1'b0;
    tbl_we = 1'b0; tbl_widx = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);

    // table image: mix of leaves and subtable pointers
    for (int i = 0; i < TSIZE; i++) begin
      logic [31:0] e;
      if ((i % 4) == 1 || (i % 4) == 2) e = {1'b0, 15'h0, 16'((i * 53 + 7) & 16'hFFFF)};
      else e = {1'b1, 15'h2A5, 16'((i * 29 + 3) & 16'hFFFF)};
      table_m[i] = e;
      @(negedge clk);
      tbl_we = 1'b1; tbl_widx = AW'(i); tbl_wdata = e;
    end
    @(negedge clk);
    tbl_we = 1'b0;
    repeat (2) @(negedge clk);

    // R9 timing per depth, with R4 hop check on the leaf case
    ready_mode = 1;
    for (int L = 1; L <= 3; L++) begin
      logic [31:0] a;
      logic [HOP_W-1:0] h; int lv; bit p3;
      a = find_addr(L, 0);
      h = walk(a, lv, p3);
      drain();
      send(a);
      drain();
      check(last_pop_cyc == acc_cyc + 1 + 4 * L, "R9", "result cycle", last_pop_cyc,
            acc_cyc + 1 + 4 * L);
      if (L == 1) check(last_pop_hop == h, "R4", "leaf low bits", last_pop_hop, h);
    end

    // R3: third entry without leaf bit still delivers its low bits
    begin
      logic [31:0] a;
      logic [HOP_W-1:0] h; int lv; bit p3;
      a = find_addr(3, 1);
      h = walk(a, lv, p3);
      send(a);
      drain();
      check(p3 && last_pop_hop == h, "R3", "non-leaf third entry", last_pop_hop, h);
    end

    // R7: recirculation takes the memory from a new address
    begin
      logic [31:0] a;
      int a0;
      a = find_addr(2, 0);
      send(a);
      a0 = acc_cyc;
      while (cyc < a0 + 3) @(negedge clk);
      #1;
      check(in_ready == 1'b1, "R7", "ready before recirculation", in_ready, 1);
      @(negedge clk); #1;
      check(in_ready == 1'b0, "R7", "ready during recirculation", in_ready, 0);
      drain();
    end

    // R6: token exhaustion while the output is blocked
    begin
      int k = 0;
      ready_mode = 0;
      for (int c = 0; c < 40; c++) begin
        logic [31:0] a;
        int lv; bit p3; logic [HOP_W-1:0] h;
        a = rnd();
        in_valid = 1'b1; in_addr = a;
        #1;
        if (in_ready) begin
          h = walk(a, lv, p3);
          exp_hop.push_back(h); exp_lv.push_back(lv);
          n_sent++; k++;
        end
        @(negedge clk);
      end
      in_valid = 1'b0;
      #1;
      check(k == NTOK, "R6", "accepted while blocked", k, NTOK);
      check(in_ready == 1'b0, "R6", "ready with no token", in_ready, 0);
      ready_mode = 2;
      drain();
    end

    // random traffic with a throttled output
    ready_mode = 2;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] g;
      g = rnd();
      send(rnd());
      if (g[1:0] == 2'b00) @(negedge clk);
    end
    // back-to-back traffic with an open output
    ready_mode = 1;
    for (int n = 0; n < 200; n++) send(rnd());
    drain();
    check(n_out == n_sent, "R5", "one result per address", n_out, n_sent);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule